// File: doc/BRIEF.md
# Printer Port Host Register File

This block is the byte-wide register file behind a legacy PC-style printer port. A host reaches it through an access channel that uses valid/ready. The channel carries a write flag, an address and write data, and only the low three address bits choose a register. Inside are the output data byte, a read-only status byte built from the connector inputs, a control byte, and two general EPP address/data holding registers. The block drives the connector's data lines and control lines. It produces a registered strobe pulse after each data write, and it can turn the data lines around to sample external data.

The access channel applies back-pressure. `acc_ready` is low from the cycle a data write is accepted until its strobe pulse has ended, and no access of any kind is taken during that time. The host must hold `acc_valid` and all access fields steady until it sees `acc_ready` high at a clock edge. The block answers every accepted read with a one-cycle `rd_valid` pulse carrying `rd_data`. Read responses cannot be stalled.

An acknowledge pulse on the connector is the active-low input `ack_n_i`. Its falling edge raises a level interrupt when control bit 4 is set. A host read of the status register lowers that interrupt.

Top module: `lpt_host_regs`

## Requirements
- R1: After reset, the data register is 0x00 and the control register is 0xC0. `strobe_o` and `irq_o` are low, and the data lines are driven (`pd_oe` high).
- R2: Register selection uses only `acc_addr[2:0]`, and the higher address bits have no effect. Offset 0 is data, 1 status, 2 control, 3 EPP address and 4 EPP data.
- R3: A control write stores the written byte with bits 7 and 6 forced to 1. The stored byte reads back at offset 2 and appears on `ctl_o`.
- R4: `pd_oe` is the inverse of control bit 5. With bit 5 clear, a read of offset 0 returns the last byte written there. With bit 5 set, it returns `pd_in` as sampled in the acceptance cycle.
- R5: A data write puts the byte on `pd_out` at the acceptance edge. `strobe_o` rises one cycle later and stays high for exactly STROBE_CYC cycles, while `pd_out` holds steady. `acc_ready` is low from the acceptance edge until the edge at which the strobe falls.
- R6: A falling edge on `ack_n_i` sets `irq_o` on the third clock edge after the input changes, but only when control bit 4 is set. A rising edge never sets it.
- R7: The status byte reads as follows: bit 7 `busy_i`, bit 6 the synchronised acknowledge level, bit 5 `paper_out_i`, bit 4 `select_i`, bit 3 `error_i`, bit 2 the pending interrupt, bit 1 constant 1, bit 0 constant 0 (timeout, never set). An accepted status read clears `irq_o` at the acceptance edge.
- R8: Writes to offsets 3 and 4 load the EPP address and EPP data registers, and reads of those offsets return the stored bytes.
- R9: Reads of offsets 5, 6 and 7 return 0xFF. Writes to them change no register or output.
- R10: `rd_valid` is high for exactly one cycle after each accepted read, with `rd_data` valid alongside it. It never pulses for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access accepted at this edge when high with acc_valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address; low 3 bits select the register |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 8 | Read response data |
| pd_out | output | 8 | Data lines driven to the connector |
| pd_oe | output | 1 | Data line drive enable |
| pd_in | input | 8 | Data lines sampled from the connector |
| strobe_o | output | 1 | Data strobe pulse, active high |
| ctl_o | output | 8 | Control register contents |
| busy_i | input | 1 | Printer busy |
| ack_n_i | input | 1 | Acknowledge, active low, asynchronous |
| paper_out_i | input | 1 | Paper out |
| select_i | input | 1 | Printer selected |
| error_i | input | 1 | Printer error |
| irq_o | output | 1 | Acknowledge interrupt, level |

## Verification
Read data and `rd_valid` are due one edge after acceptance. `pd_out`, the cleared interrupt and the loss of `acc_ready` are due at the acceptance edge itself. The strobe occupies the second through (STROBE_CYC+1)th edges after a data write. The interrupt rises on the third edge after `ack_n_i` falls. The bench drives and samples only on falling clock edges, and it counts edges explicitly from each stimulus to the expected change. It checks before and after every such boundary so that a result one cycle early or late fails.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EPPA = 3'd3;
  localparam logic [2:0] OFS_EPPD = 3'd4;

  localparam int CTL_BIDIR_BIT = 5;
  localparam int CTL_ACKIE_BIT = 4;

  localparam logic [7:0] CTL_FORCED  = 8'hC0;
  localparam logic [7:0] UNMAPPED_RD = 8'hFF;

  typedef enum logic [1:0] {
    STB_IDLE  = 2'd0,
    STB_SETUP = 2'd1,
    STB_PULSE = 2'd2
  } stb_state_e;
endpackage

// File: rtl/lpt_strobe_gen.sv
module lpt_strobe_gen #(
  parameter int STROBE_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic strobe
);
  import lpt_pkg::*;

  localparam int CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STROBE_CYC - 1);

  stb_state_e       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= STB_IDLE;
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      case (state)
        STB_IDLE: if (start) state <= STB_SETUP;
        STB_SETUP: begin
          state  <= STB_PULSE;
          strobe <= 1'b1;
          cnt    <= CNT_LOAD;
        end
        STB_PULSE: begin
          if (cnt == '0) begin
            state  <= STB_IDLE;
            strobe <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= STB_IDLE;
      endcase
    end
  end

  assign idle = (state == STB_IDLE);
endmodule

// File: rtl/lpt_ack_irq.sv
module lpt_ack_irq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_i,
  input  logic irq_en,
  input  logic irq_clr,
  output logic ack_level,
  output logic irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   ack_prev;
  logic                   ack_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q   <= '1;
      ack_prev <= 1'b1;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], ack_n_i};
      ack_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  assign ack_level = sync_q[SYNC_STAGES-1];
  assign ack_fall  = ack_prev & ~ack_level;

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (ack_fall & irq_en) irq <= 1'b1;
    else if (irq_clr)           irq <= 1'b0;
  end
endmodule

// File: rtl/lpt_host_regs.sv
module lpt_host_regs #(
  parameter int ADDR_W     = 10,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [7:0]        acc_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  input  logic [7:0]        pd_in,
  output logic              strobe_o,
  output logic [7:0]        ctl_o,
  input  logic              busy_i,
  input  logic              ack_n_i,
  input  logic              paper_out_i,
  input  logic              select_i,
  input  logic              error_i,
  output logic              irq_o
);
  import lpt_pkg::*;

  logic [2:0] ofs;
  logic       fire, wr_fire, rd_fire;
  logic [7:0] data_q, ctl_q, eppa_q, eppd_q;
  logic [7:0] status_v, rd_mux;
  logic       ack_level, stb_idle;
  logic       addr_hi_unused;

  assign ofs            = acc_addr[2:0];
  assign addr_hi_unused = ^acc_addr[ADDR_W-1:3];
  assign fire           = acc_valid & acc_ready;
  assign wr_fire        = fire & acc_write;
  assign rd_fire        = fire & ~acc_write;

  lpt_strobe_gen #(.STROBE_CYC(STROBE_CYC)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_fire && ofs == OFS_DATA),
    .idle   (stb_idle),
    .strobe (strobe_o)
  );

  lpt_ack_irq #(.SYNC_STAGES(2)) u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n_i   (ack_n_i),
    .irq_en    (ctl_q[CTL_ACKIE_BIT]),
    .irq_clr   (rd_fire && ofs == OFS_STAT),
    .ack_level (ack_level),
    .irq       (irq_o)
  );

  assign acc_ready = stb_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= 8'h00;
      ctl_q  <= CTL_FORCED;
      eppa_q <= 8'h00;
      eppd_q <= 8'h00;
    end else if (wr_fire) begin
      case (ofs)
        OFS_DATA: data_q <= acc_wdata;
        OFS_CTRL: ctl_q  <= acc_wdata | CTL_FORCED;
        OFS_EPPA: eppa_q <= acc_wdata;
        OFS_EPPD: eppd_q <= acc_wdata;
        default: ;
      endcase
    end
  end

  assign status_v = {busy_i, ack_level, paper_out_i, select_i, error_i,
                     irq_o, 1'b1, 1'b0};

  always_comb begin
    case (ofs)
      OFS_DATA: rd_mux = ctl_q[CTL_BIDIR_BIT] ? pd_in : data_q;
      OFS_STAT: rd_mux = status_v;
      OFS_CTRL: rd_mux = ctl_q;
      OFS_EPPA: rd_mux = eppa_q;
      OFS_EPPD: rd_mux = eppd_q;
      default:  rd_mux = UNMAPPED_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_mux;
    end
  end

  assign pd_out = data_q;
  assign pd_oe  = ~ctl_q[CTL_BIDIR_BIT];
  assign ctl_o  = ctl_q;
endmodule

// File: rtl/lpt_host_regs_chk.sv
module lpt_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic       acc_write,
  input logic       rd_valid,
  input logic [7:0] ctl_o,
  input logic [7:0] pd_out,
  input logic       strobe_o,
  input logic       irq_o
);
  // R3
  ctl_rsv_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o[7:6] == 2'b11);

  // R5
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |-> ($stable(pd_out) && !acc_ready));

  // R10
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_write) |=> rd_valid);

  // R10
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && acc_ready && !acc_write));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(ctl_o[4]));
endmodule

bind lpt_host_regs lpt_host_regs_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_write (acc_write),
  .rd_valid  (rd_valid),
  .ctl_o     (ctl_o),
  .pd_out    (pd_out),
  .strobe_o  (strobe_o),
  .irq_o     (irq_o)
);

// File: tb/lpt_host_regs_tb.sv
module lpt_host_regs_tb;
  localparam int ADDR_W = 10;
  localparam int STB    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0, pd_in = '0;
  logic busy_i = 0, ack_n_i = 1, paper_out_i = 0, select_i = 0, error_i = 0;
  logic acc_ready, rd_valid, pd_oe, strobe_o, irq_o;
  logic [7:0] rd_data, pd_out, ctl_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lpt_host_regs #(.ADDR_W(ADDR_W), .STROBE_CYC(STB)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .strobe_o(strobe_o), .ctl_o(ctl_o), .busy_i(busy_i),
    .ack_n_i(ack_n_i), .paper_out_i(paper_out_i), .select_i(select_i),
    .error_i(error_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic wr(input logic [6:0] hi, input logic [2:0] ofs, input logic [7:0] d);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = {hi, ofs}; acc_wdata = d;
    @(posedge clk); @(negedge clk);
    acc_valid = 0; acc_write = 0;
    chk("R10 no rd_valid on write", {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic rd(input logic [6:0] hi, input logic [2:0] ofs, output logic [7:0] v);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = {hi, ofs};
    @(posedge clk); @(negedge clk);
    acc_valid = 0;
    chk("R10 rd_valid", {7'd0, rd_valid}, 8'd1);
    v = rd_data;
  endtask

  task automatic idle_wait();
    while (!acc_ready) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got 0 exp 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v, d_last;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl_o", ctl_o, 8'hC0);
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 strobe", {7'd0, strobe_o}, 8'd0);
    chk("R1 irq", {7'd0, irq_o}, 8'd0);
    chk("R1 pd_oe", {7'd0, pd_oe}, 8'd1);
    rd(7'd0, 3'd2, v); chk("R1 ctl read", v, 8'hC0);
    rd(7'd0, 3'd0, v); chk("R1 data read", v, 8'h00);

    // R3 R4 R5 sweep over every control and data value
    for (int i = 0; i < 256; i++) begin
      d_last = 8'(i) ^ 8'h3C;
      wr(7'(i), 3'd0, d_last);
      chk("R5 pd_out at accept", pd_out, d_last);
      chk("R5 strobe low in setup", {7'd0, strobe_o}, 8'd0);
      chk("R5 ready low", {7'd0, acc_ready}, 8'd0);
      for (int k = 0; k < STB; k++) begin
        @(negedge clk);
        chk("R5 strobe high", {7'd0, strobe_o}, 8'd1);
        chk("R5 ready low in pulse", {7'd0, acc_ready}, 8'd0);
      end
      @(negedge clk);
      chk("R5 strobe ends", {7'd0, strobe_o}, 8'd0);
      chk("R5 ready back", {7'd0, acc_ready}, 8'd1);
      chk("R5 pd_out held", pd_out, d_last);
      wr(7'(255 - i), 3'd2, 8'(i) & 8'hEF);
      chk("R3 ctl_o", ctl_o, (8'(i) & 8'hEF) | 8'hC0);
      chk("R4 pd_oe", {7'd0, pd_oe}, {7'd0, ~i[5]});
      rd(7'(i * 3), 3'd2, v); chk("R3 ctl readback", v, (8'(i) & 8'hEF) | 8'hC0);
      pd_in = 8'(i) ^ 8'hA5;
      rd(7'(i), 3'd0, v); chk("R4 data read source", v, i[5] ? pd_in : d_last);
    end

    // R2 R8 address aliasing on EPP registers
    for (int h = 0; h < 128; h++) begin
      wr(7'(h), 3'd3, 8'(h * 5 + 1));
      wr(7'(h ^ 7'h55), 3'd4, 8'(h * 7 + 2));
      rd(7'(127 - h), 3'd3, v); chk("R8 R2 epp addr", v, 8'(h * 5 + 1));
      rd(7'(h * 3), 3'd4, v); chk("R8 R2 epp data", v, 8'(h * 7 + 2));
    end

    // R9 unmapped offsets
    wr(7'd0, 3'd2, 8'h00);
    wr(7'd0, 3'd0, 8'h5A);
    for (int o = 5; o < 8; o++) begin
      wr(7'd9, 3'(o), 8'h12);
      chk("R9 no strobe", {7'd0, strobe_o}, 8'd0);
      rd(7'd9, 3'(o), v); chk("R9 reads FF", v, 8'hFF);
    end
    chk("R9 ctl_o unchanged", ctl_o, 8'hC0);
    chk("R9 pd_out unchanged", pd_out, 8'h5A);
    rd(7'd0, 3'd3, v); chk("R9 epp addr unchanged", v, 8'(127 * 5 + 1));
    rd(7'd0, 3'd4, v); chk("R9 epp data unchanged", v, 8'(127 * 7 + 2));

    // R7 status layout sweep
    for (int s = 0; s < 32; s++) begin
      {busy_i, paper_out_i, select_i, error_i, v[0]} = 5'(s);
      rd(7'(s), 3'd1, v);
      chk("R7 status layout", v, {s[4], 1'b1, s[3], s[2], s[1], 1'b0, 1'b1, 1'b0});
    end
    {busy_i, paper_out_i, select_i, error_i} = 4'd0;

    // R6 interrupt enabled
    wr(7'd0, 3'd2, 8'h10);
    for (int n = 0; n < 3; n++) begin
      ack_n_i = 0;
      @(negedge clk); chk("R6 irq edge1", {7'd0, irq_o}, 8'd0);
      @(negedge clk); chk("R6 irq edge2", {7'd0, irq_o}, 8'd0);
      @(negedge clk); chk("R6 irq edge3", {7'd0, irq_o}, 8'd1);
      rd(7'd0, 3'd1, v); chk("R7 status irq pending, ack low", v, 8'h06);
      chk("R7 irq cleared", {7'd0, irq_o}, 8'd0);
      ack_n_i = 1;
      repeat (5) @(negedge clk);
      chk("R6 rising no irq", {7'd0, irq_o}, 8'd0);
    end
    // R6 interrupt disabled
    wr(7'd0, 3'd2, 8'h00);
    ack_n_i = 0;
    repeat (6) @(negedge clk);
    chk("R6 disabled no irq", {7'd0, irq_o}, 8'd0);
    ack_n_i = 1;
    repeat (4) @(negedge clk);
    idle_wait();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule